// File: doc/BRIEF.md
# Bus Error Capture Register Pair

This block keeps a record of errors seen on a host bridge's DMA and PIO transactions. It holds two status words and one shared address word. The uncorrectable status word covers read, write and translation errors. The correctable status word covers read and write errors and also keeps an ECC syndrome. A separate detection stage presents each error as a single-cycle event. The event carries its class, its direction, a byte mask, a doubleword offset, a block flag, a syndrome and the faulting address.

The first error of a status word becomes its primary error. Only a primary error loads the detail fields, and it also loads the shared address word. Any later error of either class sets only the matching secondary bit, and it does so until software clears every primary bit of that word. Software reads the words over a plain 64-bit register port. It clears error bits by writing ones to them, so writing back the value just read clears exactly the bits that were set. Each status word drives an interrupt while one of its primary bits is set and the interrupt enable input is high.

Top module: `bus_err_capture`

## Requirements
- R1: After reset, both status words and the address word read as zero, and both interrupts are low.
- R2: An error event finds no primary bit set in its status word after this cycle's clear. It then sets the primary bit for its kind (ev_kind 0 read, 1 write, 2 translation). In the uncorrectable word the read, write and translation primary bits are bits 62, 61 and 56. In the correctable word the read and write primary bits are bits 62 and 61.
- R3: A primary capture loads the byte mask into bits 47:32, the doubleword offset into bits 31:29 and the block flag into bit 23. In the correctable word it also loads the syndrome into bits 55:48. In the uncorrectable word bits 55:48 stay zero.
- R4: An event that arrives while its word has a primary bit set sets only the secondary bit for its kind. The uncorrectable word uses bits 59 (read), 58 (write) and 57 (translation). The correctable word uses bits 59 (read) and 58 (write). The primary bits, the detail fields and the address word keep their values.
- R5: A write to a status word clears each error bit at which the written data has a 1. Zeros leave bits unchanged, and the detail fields ignore writes. Writing back a value just read clears exactly the error bits that were set.
- R6: The address word loads the event address on every primary capture in either status word. At no other time does it change, and register writes to it are ignored. It reads, zero-extended, at both select 1 and select 3.
- R7: In the correctable word a translation event has no effect, and a kind-3 event changes neither word.
- R8: irq_uncorr (irq_corr) is high exactly when a primary bit of the uncorrectable (correctable) word is set and irq_en is high.
- R9: When an event and a clearing write hit the same word in one cycle, the event's bit ends up set. If the write clears every primary bit, the event is captured as a new primary error.
- R10: ev_uncorr=1 routes an event to the uncorrectable word and ev_uncorr=0 routes it to the correctable word. The other word stays unchanged. Register select 0 reads the uncorrectable word, select 2 the correctable word, and other unused selects read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Error event present this cycle |
| ev_uncorr | input | 1 | 1: uncorrectable word, 0: correctable word |
| ev_kind | input | 2 | 0 read, 1 write, 2 translation, 3 reserved |
| ev_bmask | input | 16 | Byte mask of the failing transfer |
| ev_off | input | 3 | Doubleword offset (address bits 5:3) |
| ev_blk | input | 1 | Transfer was a block operation |
| ev_synd | input | 8 | ECC syndrome |
| ev_addr | input | ADDR_W | Faulting address |
| irq_en | input | 1 | Error interrupt enable |
| reg_sel | input | SEL_W | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_sel |
| irq_uncorr | output | 1 | Uncorrectable error interrupt |
| irq_corr | output | 1 | Correctable error interrupt |

## Verification
The assertions rely on the inputs carrying at most one event per cycle, so at most one status word captures in a cycle. They also rely on writes reaching a status word only through reg_sel values 0 and 2. The bench keeps to this by raising ev_valid for a single cycle with a single routing bit and by driving every input at the falling edge. The sweep runs every ordered pair of class and kind combinations from a cleared start. It covers the reserved and unsupported kinds, and a separate set of cases drives an event and a clearing write in the same cycle.

// File: rtl/bus_err_capture_pkg.sv
package bus_err_capture_pkg;

    localparam int WORD_W  = 64;
    localparam int BMASK_W = 16;
    localparam int OFF_W   = 3;
    localparam int SYND_W  = 8;
    localparam int KIND_N  = 3;

    // Error bit positions shared with software decode.
    localparam int B_PRIM_RD = 62;
    localparam int B_PRIM_WR = 61;
    localparam int B_SEC_RD  = 59;
    localparam int B_SEC_WR  = 58;
    localparam int B_SEC_TX  = 57;
    localparam int B_PRIM_TX = 56;
    localparam int SYND_LSB  = 48;
    localparam int BMASK_LSB = 32;
    localparam int OFF_LSB   = 29;
    localparam int B_BLK     = 23;

    // Register select codes.
    localparam int SEL_UNCORR     = 0;
    localparam int SEL_ADDR       = 1;
    localparam int SEL_CORR       = 2;
    localparam int SEL_ADDR_ALIAS = 3;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_XLATE = 2'd2,
        KIND_RSVD  = 2'd3
    } err_kind_e;

    // Index 0 read, 1 write, 2 translation.
    typedef struct packed {
        logic [KIND_N-1:0]  prim;
        logic [KIND_N-1:0]  sec;
        logic [BMASK_W-1:0] bmask;
        logic [OFF_W-1:0]   off;
        logic               blk;
        logic [SYND_W-1:0]  synd;
    } stat_t;

    function automatic logic [WORD_W-1:0] pack_word(input stat_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_PRIM_RD] = s.prim[0];
        w[B_PRIM_WR] = s.prim[1];
        w[B_PRIM_TX] = s.prim[2];
        w[B_SEC_RD]  = s.sec[0];
        w[B_SEC_WR]  = s.sec[1];
        w[B_SEC_TX]  = s.sec[2];
        w[SYND_LSB  +: SYND_W]  = s.synd;
        w[BMASK_LSB +: BMASK_W] = s.bmask;
        w[OFF_LSB   +: OFF_W]   = s.off;
        w[B_BLK] = s.blk;
        return w;
    endfunction

endpackage

// File: rtl/errcap_status.sv
module errcap_status
    import bus_err_capture_pkg::*;
#(
    parameter bit HAS_XLATE = 1'b1,
    parameter bit HAS_SYND  = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_hit,
    input  logic [1:0]         ev_kind,
    input  logic [BMASK_W-1:0] ev_bmask,
    input  logic [OFF_W-1:0]   ev_off,
    input  logic               ev_blk,
    input  logic [SYND_W-1:0]  ev_synd,
    input  logic               wr_sel,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               irq_en,
    output logic [WORD_W-1:0]  stat_word,
    output logic               capture,
    output logic               irq
);

    stat_t stat_q, stat_d, after_clr;
    logic [KIND_N-1:0] kind_mask;
    logic [KIND_N-1:0] clr_prim, clr_sec;
    logic [KIND_N-1:0] kind_oh;
    logic [SYND_W-1:0] synd_in;
    logic              kind_ok, prim_busy;
    logic              unused_wbits;

    generate
        if (HAS_XLATE) begin : g_tx
            assign kind_mask = 3'b111;
        end else begin : g_no_tx
            assign kind_mask = 3'b011;
        end
    endgenerate

    assign synd_in      = ev_synd & {SYND_W{HAS_SYND}};
    assign unused_wbits = ^{wr_data[63], wr_data[60], wr_data[55:0]};

    always_comb begin
        clr_prim = '0;
        clr_sec  = '0;
        if (wr_sel) begin
            clr_prim = {wr_data[B_PRIM_TX], wr_data[B_PRIM_WR], wr_data[B_PRIM_RD]} & kind_mask;
            clr_sec  = {wr_data[B_SEC_TX],  wr_data[B_SEC_WR],  wr_data[B_SEC_RD]}  & kind_mask;
        end
        after_clr      = stat_q;
        after_clr.prim = stat_q.prim & ~clr_prim;
        after_clr.sec  = stat_q.sec  & ~clr_sec;

        kind_oh   = KIND_N'(3'b001 << ev_kind);
        kind_ok   = ev_hit && (ev_kind != KIND_RSVD) && |(kind_oh & kind_mask);
        prim_busy = |after_clr.prim;

        stat_d  = after_clr;
        capture = 1'b0;
        if (kind_ok) begin
            if (!prim_busy) begin
                stat_d.prim  = after_clr.prim | kind_oh;
                stat_d.bmask = ev_bmask;
                stat_d.off   = ev_off;
                stat_d.blk   = ev_blk;
                stat_d.synd  = synd_in;
                capture      = 1'b1;
            end else begin
                stat_d.sec = after_clr.sec | kind_oh;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_word = pack_word(stat_q);
    assign irq       = (|stat_q.prim) & irq_en;

    // R4
    sec_keeps_detail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_q.prim && !wr_sel) |=> ($stable(stat_q.bmask) && $stable(stat_q.off)
                                       && $stable(stat_q.blk) && $stable(stat_q.synd)
                                       && |stat_q.prim));
    // R2
    capture_sets_prim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> |(stat_q.prim & $past(kind_oh)));
    // R5
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !ev_hit) |=> ((stat_q.prim & $past(clr_prim)) == '0
                                 && (stat_q.sec & $past(clr_sec)) == '0));
    // R9
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && kind_ok) |=> |((stat_q.prim | stat_q.sec) & $past(kind_oh)));
    // R8
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && irq_en) |=> (irq || !irq_en));
    // R7
    unsupported_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_hit && !kind_ok && !wr_sel) |=> $stable(stat_q));

endmodule

// File: rtl/errcap_addr.sv
module errcap_addr #(
    parameter int ADDR_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_a,
    input  logic              cap_b,
    input  logic [ADDR_W-1:0] ev_addr,
    output logic [ADDR_W-1:0] addr_q
);

    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (cap_a || cap_b) addr_d = ev_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_a || cap_b) |=> $stable(addr_q));
    // R6
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_a || cap_b) |=> (addr_q == $past(ev_addr)));
    // R10
    single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_a, cap_b}));

endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
    import bus_err_capture_pkg::*;
#(
    parameter int ADDR_W = 34,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_uncorr,
    input  logic [1:0]        ev_kind,
    input  logic [15:0]       ev_bmask,
    input  logic [2:0]        ev_off,
    input  logic              ev_blk,
    input  logic [7:0]        ev_synd,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              irq_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              irq_uncorr,
    output logic              irq_corr
);

    localparam int ADDR_PAD = WORD_W - ADDR_W;

    logic [WORD_W-1:0] uc_word, ce_word;
    logic [ADDR_W-1:0] addr_q;
    logic              uc_cap, ce_cap;
    logic              uc_hit, ce_hit, uc_wr, ce_wr;

    assign uc_hit = ev_valid &&  ev_uncorr;
    assign ce_hit = ev_valid && !ev_uncorr;
    assign uc_wr  = reg_wr && (reg_sel == SEL_W'(SEL_UNCORR));
    assign ce_wr  = reg_wr && (reg_sel == SEL_W'(SEL_CORR));

    errcap_status #(.HAS_XLATE(1'b1), .HAS_SYND(1'b0)) u_uncorr (
        .clk(clk), .rst_n(rst_n), .ev_hit(uc_hit), .ev_kind(ev_kind),
        .ev_bmask(ev_bmask), .ev_off(ev_off), .ev_blk(ev_blk), .ev_synd(ev_synd),
        .wr_sel(uc_wr), .wr_data(reg_wdata), .irq_en(irq_en),
        .stat_word(uc_word), .capture(uc_cap), .irq(irq_uncorr)
    );

    errcap_status #(.HAS_XLATE(1'b0), .HAS_SYND(1'b1)) u_corr (
        .clk(clk), .rst_n(rst_n), .ev_hit(ce_hit), .ev_kind(ev_kind),
        .ev_bmask(ev_bmask), .ev_off(ev_off), .ev_blk(ev_blk), .ev_synd(ev_synd),
        .wr_sel(ce_wr), .wr_data(reg_wdata), .irq_en(irq_en),
        .stat_word(ce_word), .capture(ce_cap), .irq(irq_corr)
    );

    errcap_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .cap_a(uc_cap), .cap_b(ce_cap),
        .ev_addr(ev_addr), .addr_q(addr_q)
    );

    always_comb begin
        case (reg_sel)
            SEL_W'(SEL_UNCORR):     reg_rdata = uc_word;
            SEL_W'(SEL_CORR):       reg_rdata = ce_word;
            SEL_W'(SEL_ADDR),
            SEL_W'(SEL_ADDR_ALIAS): reg_rdata = {{ADDR_PAD{1'b0}}, addr_q};
            default:                reg_rdata = '0;
        endcase
    end

    // R10
    route_corr_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uc_hit && !ce_wr) |=> $stable(ce_word));
    // R10
    route_uncorr_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_hit && !uc_wr) |=> $stable(uc_word));
    // R3
    no_synd_in_uncorr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uc_word[55:48] == 8'h00);

endmodule

// File: tb/bus_err_capture_test.sv
module bus_err_capture_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 34;
    localparam logic [63:0] UC_ERR  = 64'h6F00_0000_0000_0000;
    localparam logic [63:0] CE_ERR  = 64'h6C00_0000_0000_0000;
    localparam logic [63:0] UC_PRIM = 64'h6100_0000_0000_0000;
    localparam logic [63:0] CE_PRIM = 64'h6000_0000_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_valid = 1'b0, ev_uncorr = 1'b0, ev_blk = 1'b0, irq_en = 1'b0, reg_wr = 1'b0;
    logic [1:0] ev_kind = '0;
    logic [15:0] ev_bmask = '0;
    logic [2:0] ev_off = '0, reg_sel = '0;
    logic [7:0] ev_synd = '0;
    logic [AW-1:0] ev_addr = '0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic irq_uncorr, irq_corr;

    int checks = 0, fails = 0;
    logic [63:0] m_uc = '0, m_ce = '0, m_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_err_capture #(.ADDR_W(AW), .SEL_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_uncorr(ev_uncorr),
        .ev_kind(ev_kind), .ev_bmask(ev_bmask), .ev_off(ev_off), .ev_blk(ev_blk),
        .ev_synd(ev_synd), .ev_addr(ev_addr), .irq_en(irq_en), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_uncorr(irq_uncorr), .irq_corr(irq_corr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Model: bit numbers as stated in the requirements.
    function automatic int prim_bit(input int k);
        return (k == 0) ? 62 : (k == 1) ? 61 : 56;
    endfunction
    function automatic int sec_bit(input int k);
        return (k == 0) ? 59 : (k == 1) ? 58 : 57;
    endfunction

    function automatic logic [63:0] m_event(input logic [63:0] s, input bit uc, input int k,
        input logic [15:0] bm, input logic [2:0] off, input bit blk, input logic [7:0] syn,
        output bit cap);
        logic [63:0] r;
        r = s;
        cap = 1'b0;
        if (k == 3 || (!uc && k == 2)) return r;
        if ((s & (uc ? UC_PRIM : CE_PRIM)) == 64'd0) begin
            r[prim_bit(k)] = 1'b1;
            r[47:32] = bm;
            r[31:29] = off;
            r[23] = blk;
            if (!uc) r[55:48] = syn;
            cap = 1'b1;
        end else begin
            r[sec_bit(k)] = 1'b1;
        end
        return r;
    endfunction

    // One clock: optional event and optional write, model updated clear-then-event.
    task automatic cyc(input bit ev, input bit uc, input int k, input logic [15:0] bm,
                       input logic [2:0] off, input bit blk, input logic [7:0] syn,
                       input logic [AW-1:0] a, input bit wr, input int sel, input logic [63:0] d);
        bit cap;
        @(negedge clk);
        ev_valid = ev; ev_uncorr = uc; ev_kind = 2'(k); ev_bmask = bm; ev_off = off;
        ev_blk = blk; ev_synd = syn; ev_addr = a;
        reg_wr = wr; reg_sel = 3'(sel); reg_wdata = d;
        if (wr && sel == 0) m_uc = m_uc & ~(d & UC_ERR);
        if (wr && sel == 2) m_ce = m_ce & ~(d & CE_ERR);
        if (ev) begin
            if (uc) m_uc = m_event(m_uc, 1'b1, k, bm, off, blk, syn, cap);
            else    m_ce = m_event(m_ce, 1'b0, k, bm, off, blk, syn, cap);
            if (cap) m_addr = {30'd0, a};
        end
        @(negedge clk);
        ev_valid = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rdw(input int sel, output logic [63:0] d);
        @(negedge clk);
        reg_sel = 3'(sel);
        #1 d = reg_rdata;
    endtask

    task automatic ev_only(input bit uc, input int k, input int seed);
        cyc(1'b1, uc, k, 16'(16'hA500 + seed * 37), 3'(seed), seed[0], 8'(8'h30 + seed * 5),
            AW'(34'h2_0000_0000 + seed * 264), 1'b0, 0, 64'd0);
    endtask

    task automatic wr_only(input int sel, input logic [63:0] d);
        cyc(1'b0, 1'b0, 0, '0, '0, 1'b0, '0, '0, 1'b1, sel, d);
    endtask

    task automatic check_all(input string req);
        logic [63:0] v;
        rdw(0, v); chk({req, " uncorr word"}, v, m_uc);
        rdw(2, v); chk({req, " corr word"}, v, m_ce);
        rdw(1, v); chk({req, " addr word"}, v, m_addr);
        chk({req, " irq_uncorr"}, 64'(irq_uncorr), 64'(((m_uc & UC_PRIM) != 0) && irq_en));
        chk({req, " irq_corr"}, 64'(irq_corr), 64'(((m_ce & CE_PRIM) != 0) && irq_en));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [63:0] v, a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        irq_en = 1'b1;
        // R1 reset state
        check_all("R1");
        rdw(3, v); chk("R1 alias", v, 64'd0);

        // R2 R3 R4 R7 R10: every ordered pair of (class, kind) events from clear
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                wr_only(0, '1);
                wr_only(2, '1);
                ev_only(a[2], a % 4, a * 8 + b);
                ev_only(b[2], b % 4, 64 + a + b * 8);
                check_all("R2 R3 R4 R7 R10 sweep");
            end
        end

        // R5 write-back of the read value clears exactly the set bits
        wr_only(0, '1); wr_only(2, '1);
        ev_only(1'b1, 0, 5); ev_only(1'b1, 2, 6); ev_only(1'b0, 1, 7); ev_only(1'b0, 0, 8);
        check_all("R5 setup");
        rdw(0, v); wr_only(0, v);
        rdw(2, v); wr_only(2, v);
        check_all("R5 write-back");
        rdw(0, v); chk("R5 uncorr errors gone", v & UC_ERR, 64'd0);
        // R5 zero write and detail-field write leave the word alone
        ev_only(1'b1, 1, 9);
        wr_only(0, 64'h0090_FFFF_E080_0000);
        check_all("R5 non-error bits");

        // R9 clearing every primary bit while an event arrives: new primary
        cyc(1'b1, 1'b1, 0, 16'h1234, 3'd5, 1'b1, 8'h00, 34'h1_2345_6788, 1'b1, 0, UC_ERR);
        check_all("R9 capture over clear");
        // R9 clearing a secondary bit while the same secondary event arrives
        ev_only(1'b1, 1, 11);
        cyc(1'b1, 1'b1, 1, 16'h0, 3'd0, 1'b0, 8'h00, 34'h0_0000_0040, 1'b1, 0, 64'h0400_0000_0000_0000);
        check_all("R9 secondary wins");
        rdw(0, v); chk("R9 secondary write bit", 64'(v[58]), 64'd1);

        // R6 address writes ignored, alias matches
        rdw(1, a0);
        wr_only(1, '1); wr_only(3, '1);
        rdw(1, v); chk("R6 addr write ignored", v, a0);
        rdw(3, v); chk("R6 alias", v, a0);
        rdw(5, v); chk("R10 unused select", v, 64'd0);

        // R8 enable gating
        irq_en = 1'b0;
        #1 chk("R8 irq gated", 64'(irq_uncorr), 64'd0);
        irq_en = 1'b1;
        #1 chk("R8 irq enabled", 64'(irq_uncorr), 64'd1);
        wr_only(0, '1);
        check_all("R8 irq drops after clear");

        // R7 reserved kind and corr translation leave everything unchanged
        wr_only(2, '1);
        ev_only(1'b0, 2, 20); ev_only(1'b0, 3, 21); ev_only(1'b1, 3, 22);
        check_all("R7 ignored kinds");
        rdw(2, v); chk("R7 corr word zero", v & CE_ERR, 64'd0);

        summary();
    end

endmodule